// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast peripheral clock into the two timing pulses an asynchronous serial port needs. The first is a sample tick at the oversampling rate. The second is a bit strobe once per bit time. The divisor word combines an integer mantissa and a fractional part. The fraction is spread over successive sample periods by stretching some of them one clock cycle longer. As a result, the average tick spacing equals the full fractional divisor, and each bit time comes out as an exact whole number of cycles.

A mode input selects 16 or 8 samples per bit. The by-16 setting tolerates more clock mismatch, and the by-8 setting reaches higher baud rates from the same clock. A transmitter or receiver shift engine uses the two outputs directly. An enable input holds the generator in a cleared, silent state. Any change of divisor or mode restarts the timing from a clean phase without producing a stray tick.

Top module: `baud_frac_gen`

## Requirements
- R1: While rst_n is low, and afterwards until the block is enabled, sample_tick and bit_strobe are both 0.
- R2: With over8 = 0, M = divisor[15:4] and F = divisor[3:0]. Count clock edges from the first edge at which the block samples enable high with a new setting. Sample tick number n (counting from 0) is high for the one cycle after edge T_n = sum over i = 0..n of (M + floor((i+1)F/16) - floor(iF/16)). Each period is therefore M or M+1 cycles.
- R3: bit_strobe is high only in a cycle where sample_tick is high. It accompanies sample ticks number K-1, 2K-1, and so on, where K is 16 when over8 = 0 and 8 when over8 = 1.
- R4: With over8 = 0, the first bit strobe follows exactly divisor cycles after the start, and later strobes follow every divisor cycles. For divisor 0x2D9 the spacing is 729 cycles.
- R5: With over8 = 1, the fraction is divisor[2:0] over a denominator of 8, and divisor[3] has no effect. The R2 timing formula uses 8 in place of 16, and the bit period is 8M + divisor[2:0] cycles.
- R6: A low enable forces both outputs to 0 from the next edge on. When enable returns high, timing restarts as in R2.
- R7: A mantissa of zero produces no sample ticks and no bit strobes.
- R8: A change of divisor or over8 while enabled produces no tick in the cycle after the change. Timing then restarts as in R2 from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator when high |
| over8 | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| divisor | input | 16 | Mantissa in [15:4], fraction in [3:0] |
| sample_tick | output | 1 | One-cycle pulse per sample period |
| bit_strobe | output | 1 | One-cycle pulse per bit time, coincident with a tick |

## Verification
The hardest case to reach is a divisor or mode change that lands on exactly the edge where the old setting would have fired a tick. A mistimed restart would show up as a one-cycle glitch in that case alone. To reach it, the bench runs the first setting for precisely its first period length minus one sample, swaps the setting at that point, and compares the new pulse train against a model started from zero. A second hard case is a fraction that carries on nearly every period (F = 15 and M = 1), which gives back-to-back one- and two-cycle periods.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic {
    OSR_BY16 = 1'b0,
    OSR_BY8  = 1'b1
  } osr_sel_e;

  // Number of sample ticks that make up one bit time.
  function automatic int unsigned ticks_per_bit(input logic lo, input int unsigned frac_w);
    return lo ? (32'd1 << (frac_w - 1)) : (32'd1 << frac_w);
  endfunction

endpackage

// File: rtl/baud_div_ctrl.sv
module baud_div_ctrl #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     over8,
  input  logic [MANT_W+FRAC_W-1:0] divisor,
  output logic                     restart,
  output logic                     run,
  output logic                     mode_lo,
  output logic [MANT_W-1:0]        mant,
  output logic [FRAC_W-1:0]        frac
);
  localparam int DIV_W = MANT_W + FRAC_W;
  localparam logic [FRAC_W-1:0] LO_MASK = {1'b0, {(FRAC_W-1){1'b1}}};

  logic [DIV_W-1:0]  div_q;
  logic              mode_q;
  logic              en_q;
  logic [FRAC_W-1:0] frac_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= baud_pkg::OSR_BY16;
      en_q   <= 1'b0;
    end else begin
      div_q  <= divisor;
      mode_q <= over8;
      en_q   <= enable;
    end
  end

  // Any new setting, or a fresh enable, clears the timing chain.
  assign restart  = !enable || !en_q || (divisor != div_q) || (over8 != mode_q);
  assign mant     = div_q[DIV_W-1:FRAC_W];
  assign frac_raw = div_q[FRAC_W-1:0];
  assign mode_lo  = mode_q;
  assign run      = en_q && (mant != '0);

  // In by-8 mode the top fraction bit is dropped.
  assign frac = (mode_q == baud_pkg::OSR_BY8) ? (frac_raw & LO_MASK) : frac_raw;

endmodule

// File: rtl/baud_phase_timer.sv
module baud_phase_timer #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic              mode_lo,
  input  logic [MANT_W-1:0] mant,
  input  logic [FRAC_W-1:0] frac,
  output logic              period_end,
  output logic              frac_carry,
  output logic              sample_tick
);
  localparam int CNT_W = MANT_W + 1;

  // Adds the fraction to the phase accumulator; returns {carry, next phase}.
  function automatic logic [FRAC_W:0] frac_step(
    input logic [FRAC_W-1:0] acc_in,
    input logic [FRAC_W-1:0] add_in,
    input logic              lo
  );
    logic [FRAC_W:0] sum;
    sum = {1'b0, acc_in} + {1'b0, add_in};
    if (lo) return {sum[FRAC_W-1], 1'b0, sum[FRAC_W-2:0]};
    return sum;
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  period_len;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_nxt;
  logic              tick_q;

  assign {frac_carry, acc_nxt} = frac_step(acc_q, frac, mode_lo);
  assign period_len = {1'b0, mant} + CNT_W'(frac_carry);
  assign cnt_nxt    = cnt_q + CNT_W'(1);
  assign period_end = run && !restart && (cnt_nxt == period_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (run) begin
      tick_q <= period_end;
      if (period_end) begin
        cnt_q <= '0;
        acc_q <= acc_nxt;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign sample_tick = tick_q;

endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter #(
  parameter int FRAC_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic period_end,
  input  logic mode_lo,
  output logic bit_last,
  output logic bit_strobe
);
  logic [FRAC_W-1:0] bcnt_q;
  logic              strobe_q;

  assign bit_last = (bcnt_q == FRAC_W'(baud_pkg::ticks_per_bit(mode_lo, FRAC_W) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q   <= '0;
      strobe_q <= 1'b0;
    end else if (restart) begin
      bcnt_q   <= '0;
      strobe_q <= 1'b0;
    end else if (period_end) begin
      strobe_q <= bit_last;
      bcnt_q   <= bit_last ? '0 : bcnt_q + FRAC_W'(1);
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign bit_strobe = strobe_q;

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     over8,
  input  logic [MANT_W+FRAC_W-1:0] divisor,
  output logic                     sample_tick,
  output logic                     bit_strobe
);
  logic              restart;
  logic              run;
  logic              mode_lo;
  logic [MANT_W-1:0] mant;
  logic [FRAC_W-1:0] frac;
  logic              period_end;
  logic              frac_carry;
  logic              bit_last;

  baud_div_ctrl #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .over8   (over8),
    .divisor (divisor),
    .restart (restart),
    .run     (run),
    .mode_lo (mode_lo),
    .mant    (mant),
    .frac    (frac)
  );

  baud_phase_timer #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .run         (run),
    .mode_lo     (mode_lo),
    .mant        (mant),
    .frac        (frac),
    .period_end  (period_end),
    .frac_carry  (frac_carry),
    .sample_tick (sample_tick)
  );

  baud_bit_counter #(.FRAC_W(FRAC_W)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .period_end (period_end),
    .mode_lo    (mode_lo),
    .bit_last   (bit_last),
    .bit_strobe (bit_strobe)
  );

endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     enable,
  input logic                     over8,
  input logic [MANT_W+FRAC_W-1:0] divisor,
  input logic                     sample_tick,
  input logic                     bit_strobe
);
  localparam int GAP_W = MANT_W + 2;

  logic [MANT_W+FRAC_W-1:0] prev_div;
  logic                     prev_mode;
  logic                     prev_en;
  logic                     new_cfg;
  logic [GAP_W-1:0]         gap_q;
  logic                     tseen_q;
  logic [FRAC_W-1:0]        tcnt_q;
  logic                     sseen_q;
  logic [MANT_W-1:0]        mant_in;

  assign mant_in = divisor[MANT_W+FRAC_W-1:FRAC_W];
  assign new_cfg = !enable || !prev_en || (divisor != prev_div) || (over8 != prev_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_div  <= '0;
      prev_mode <= 1'b0;
      prev_en   <= 1'b0;
      gap_q     <= '0;
      tseen_q   <= 1'b0;
      tcnt_q    <= '0;
      sseen_q   <= 1'b0;
    end else begin
      prev_div  <= divisor;
      prev_mode <= over8;
      prev_en   <= enable;
      if (sample_tick) gap_q <= GAP_W'(1);
      else if (gap_q != '1) gap_q <= gap_q + GAP_W'(1);
      if (new_cfg) begin
        tseen_q <= 1'b0;
        sseen_q <= 1'b0;
        tcnt_q  <= '0;
      end else begin
        if (sample_tick) tseen_q <= 1'b1;
        if (bit_strobe) begin
          sseen_q <= 1'b1;
          tcnt_q  <= '0;
        end else if (sample_tick) begin
          tcnt_q <= tcnt_q + FRAC_W'(1);
        end
      end
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && tseen_q) |-> (gap_q >= GAP_W'(mant_in)) && (gap_q <= GAP_W'(mant_in) + GAP_W'(1))); // R2

  AST_STRB_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> sample_tick); // R3

  AST_STRB_EVERY_K: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && sseen_q) |-> (tcnt_q == FRAC_W'(baud_pkg::ticks_per_bit(over8, FRAC_W) - 1))); // R3

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sample_tick && !bit_strobe)); // R6

  AST_NO_MANT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mant_in == '0) |=> !sample_tick); // R7

  AST_NO_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(divisor) || !$stable(over8)) |=> !sample_tick); // R8

endmodule

bind baud_frac_gen baud_frac_gen_chk #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .over8       (over8),
  .divisor     (divisor),
  .sample_tick (sample_tick),
  .bit_strobe  (bit_strobe)
);

// File: tb/sim_baud_frac_gen.sv
module sim_baud_frac_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        over8 = 1'b0;
  logic [15:0] divisor = 16'h0000;
  logic        sample_tick;
  logic        bit_strobe;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  baud_frac_gen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .over8       (over8),
    .divisor     (divisor),
    .sample_tick (sample_tick),
    .bit_strobe  (bit_strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Length of sample period n, written as the difference of two floors.
  function automatic int plen(input int m, input int f, input int d, input int n);
    return m + ((n + 1) * f) / d - (n * f) / d;
  endfunction

  // Drives a setting and compares every cycle against the model started from zero.
  task automatic t_stream(input logic [15:0] dv, input logic lo, input int ncyc,
                          input bit fresh, input string req);
    int m = int'(dv[15:4]);
    int f = lo ? int'(dv[2:0]) : int'(dv[3:0]);
    int d = lo ? 8 : 16;
    int n = 0;
    int nxt;
    bit et;
    bit eb;
    if (fresh) begin
      enable = 1'b0;
      @(negedge clk);
    end
    divisor = dv;
    over8 = lo;
    enable = 1'b1;
    nxt = plen(m, f, d, 0);
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      et = (m != 0) && (k == nxt);
      eb = et && ((n % d) == d - 1);
      chk({req, " tick"}, int'(sample_tick), int'(et));
      chk({req, " strobe"}, int'(bit_strobe), int'(eb));
      if (et) begin
        n++;
        nxt = nxt + plen(m, f, d, n);
      end
    end
  endtask

  task automatic t_bit_period(input logic [15:0] dv, input logic lo, input int exp, input string req);
    int first = -1;
    int second = -1;
    enable = 1'b0;
    @(negedge clk);
    divisor = dv;
    over8 = lo;
    enable = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (bit_strobe) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
      if (second >= 0) break;
    end
    chk({req, " first strobe"}, first, exp);
    chk({req, " strobe gap"}, second - first, exp);
  endtask

  task automatic t_reset();
    divisor = 16'h02D9;
    enable = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R1 tick in reset", int'(sample_tick), 0);
      chk("R1 strobe in reset", int'(bit_strobe), 0);
    end
    enable = 1'b0;
    rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R1 tick idle", int'(sample_tick), 0);
      chk("R1 strobe idle", int'(bit_strobe), 0);
    end
  endtask

  task automatic t_disable();
    t_stream(16'h0011, 1'b0, 40, 1'b1, "R6 pre");
    enable = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R6 tick off", int'(sample_tick), 0);
      chk("R6 strobe off", int'(bit_strobe), 0);
    end
    t_stream(16'h0011, 1'b0, 60, 1'b0, "R6 resume");
  endtask

  task automatic t_zero_mant();
    t_stream(16'h000F, 1'b0, 100, 1'b1, "R7");
    t_stream(16'h0007, 1'b1, 100, 1'b0, "R7 by8");
  endtask

  task automatic t_change();
    // First period of 0x055 lasts 5 cycles; swap just before it would end.
    t_stream(16'h0055, 1'b0, 5, 1'b1, "R8 old");
    t_stream(16'h0037, 1'b0, 150, 1'b0, "R8 new div");
    t_stream(16'h0037, 1'b1, 150, 1'b0, "R8 new mode");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_stream(16'h02D9, 1'b0, 800, 1'b1, "R2 115200");
    t_stream(16'h0013, 1'b0, 200, 1'b1, "R2 R3 mant1");
    t_stream(16'h001F, 1'b0, 200, 1'b1, "R2 R3 carry");
    t_stream(16'h0010, 1'b0, 64, 1'b1, "R3 every cycle");
    t_stream(16'h003F, 1'b1, 300, 1'b1, "R5 by8");
    t_bit_period(16'h02D9, 1'b0, 729, "R4");
    t_bit_period(16'h02DD, 1'b1, 365, "R5 bit3 set");
    t_bit_period(16'h02D5, 1'b1, 365, "R5 bit3 clear");
    t_disable();
    t_zero_mant();
    t_change();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule